// File: doc/BRIEF.md
# I2C Data Buffer and Status Flag Unit

This unit sits between the bit-level engine of an I2C controller and a small register bus. It holds one byte in a data register and one byte in a shift-register stage. The engine reports a finished receive byte or a finished transmit byte. Software reaches the unit through three addresses: data (0), status (1) and control (2). Every move of a byte between the two stages updates the transmit-empty, receive-not-empty and byte-transfer-complete flags. A write made while both stages are empty goes straight to the shift stage. A read made while a second byte waits in the shift stage pulls that byte forward at once.

The unit also keeps four error flags: over-run/under-run, missing acknowledge, lost arbitration and misplaced START/STOP. Hardware sets each of them, and software clears one by writing a 0 to its bit. The unit tracks whether the controller is currently bus master, and it drops that state when arbitration is lost. It also latches a STOP seen while acting as slave. That flag clears only after a status read followed by a control write.

Top module: `i2c_buf_flags`

## Requirements
- R1: After reset the status word reads 0, the control word reads 0, `is_master` is 0 and `sh_tx_valid` is 0.
- R2: In transmit mode (`eng_tx_mode`=1), a data write made while both stages are empty places the byte on `sh_tx_byte` with `sh_tx_valid`=1 and leaves transmit-empty (status bit 7) unchanged. It also clears byte-transfer-complete (status bit 2).
- R3: In transmit mode, a data write made while the shift stage is busy fills the data register and clears bit 7. On `eng_tx_done`, a waiting data byte moves to the shift stage and bit 7 is set.
- R4: In transmit mode, `eng_tx_done` with an empty data register empties the shift stage and sets bit 2. Over-run/under-run (bit 11) is set as well when control bit 0 (stretch disable) is 1 and `is_master` is 0.
- R5: In receive mode, a byte finishing into an empty data register sets receive-not-empty (bit 6). A data read returns the byte and clears bit 6.
- R6: In receive mode, a byte finishing while the data register is full waits in the shift stage and sets bit 2. When stretch is disabled and the unit is slave, bit 11 is set too. A data read then returns the older byte, moves the waiting byte in, keeps bit 6 set and clears bit 2.
- R7: `ev_nack` sets bit 10. Writing the status address with a 0 in bit 11, 10, 9 or 8 clears that flag. Writing 1 leaves it unchanged, and setting takes priority over clearing.
- R8: `mst_start` sets `is_master`. `ev_arb_lost` while master sets bit 9 and clears `is_master`. `ev_arb_lost` while slave changes nothing.
- R9: `ev_start` or `ev_stop` while `eng_mid_byte`=1 sets bus error (bit 8). The same events with `eng_mid_byte`=0 do not.
- R10: `ev_stop` while slave sets bit 4. It clears only on a control write that follows a status read made while bit 4 was set. A control write without that read leaves it set. `ev_stop` while master leaves bit 4 clear and clears `is_master`.
- R11: Status bits 15:12, 5, 3, 1 and 0 always read 0. Control bits 15:1 read 0, and control bit 0 reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects at the clock edge) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| eng_tx_mode | input | 1 | 1 transmit direction, 0 receive direction |
| eng_rx_done | input | 1 | A received byte finished shifting in |
| eng_rx_byte | input | 8 | Byte that finished arriving |
| eng_tx_done | input | 1 | Shift stage finished sending its byte |
| sh_tx_byte | output | 8 | Byte held in the shift stage |
| sh_tx_valid | output | 1 | Shift stage holds a byte to send |
| eng_mid_byte | input | 1 | A byte transfer is in progress on the bus |
| ev_start | input | 1 | START condition seen |
| ev_stop | input | 1 | STOP condition seen |
| ev_nack | input | 1 | Acknowledge missing |
| ev_arb_lost | input | 1 | Arbitration lost |
| mst_start | input | 1 | Engine started a transfer as master |
| is_master | output | 1 | Unit is currently bus master |

## Verification
The assertions assume that at most one register access is active per cycle. They also assume the engine never raises `eng_tx_done` or `eng_rx_done` in the same cycle as a data access, and that `eng_tx_mode` stays constant between resets. The bench drives each of these as a single-cycle pulse in a separate cycle and changes direction only across a reset. Over-run/under-run and flag-clearing behaviour are swept over every combination of stretch disable, master state and clear mask.

// File: rtl/i2c_buf_pkg.sv
package i2c_buf_pkg;
  localparam int DW = 8;
  localparam int RW = 16;
  localparam int NERR = 4;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam int B_ERR0 = 8;   // errors occupy B_ERR0 .. B_ERR0+NERR-1
  localparam int B_TBE  = 7;
  localparam int B_RBNE = 6;
  localparam int B_STOP = 4;
  localparam int B_BTC  = 2;

  typedef struct packed {
    logic tbe;
    logic rbne;
    logic btc;
    logic stop;
  } buf_flags_t;

  function automatic logic [RW-1:0] pack_status(input logic [NERR-1:0] errs,
                                                input buf_flags_t f);
    logic [RW-1:0] s;
    s = '0;
    s[B_ERR0 +: NERR] = errs;
    s[B_TBE]  = f.tbe;
    s[B_RBNE] = f.rbne;
    s[B_STOP] = f.stop;
    s[B_BTC]  = f.btc;
    return s;
  endfunction
endpackage

// File: rtl/i2c_w0c_flag.sv
module i2c_w0c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/i2c_byte_path.sv
module i2c_byte_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_mode,
  input  logic          wr_data,
  input  logic [DW-1:0] wdata,
  input  logic          rd_data,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_done,
  input  logic          stretch_dis,
  input  logic          slave,
  output logic [DW-1:0] dr_q,
  output logic [DW-1:0] sr_q,
  output logic          sr_full,
  output logic          tbe,
  output logic          rbne,
  output logic          btc,
  output logic          ou_event
);
  logic dr_full;
  // named internal events
  logic tx_direct, tx_fill, tx_move, tx_drain;
  logic rx_land, rx_wait, rd_pull, rd_empty;

  always_comb begin
    tx_direct = tx_mode && wr_data && !dr_full && !sr_full;
    tx_fill   = tx_mode && wr_data && (dr_full || sr_full);
    tx_move   = tx_mode && !wr_data && tx_done && sr_full && dr_full;
    tx_drain  = tx_mode && !wr_data && tx_done && sr_full && !dr_full;
    rx_land   = !tx_mode && rx_done && !dr_full;
    rx_wait   = !tx_mode && rx_done && dr_full;
    rd_pull   = !tx_mode && !rx_done && rd_data && dr_full && sr_full;
    rd_empty  = !tx_mode && !rx_done && rd_data && dr_full && !sr_full;
    ou_event  = slave && stretch_dis && (tx_drain || rx_wait);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_q <= '0; sr_q <= '0; dr_full <= 1'b0; sr_full <= 1'b0;
      tbe <= 1'b0; rbne <= 1'b0; btc <= 1'b0;
    end else begin
      if (tx_direct) begin
        sr_q <= wdata; sr_full <= 1'b1; btc <= 1'b0;
      end
      if (tx_fill) begin
        dr_q <= wdata; dr_full <= 1'b1; tbe <= 1'b0;
      end
      if (tx_move) begin
        sr_q <= dr_q; dr_full <= 1'b0; tbe <= 1'b1;
      end
      if (tx_drain) begin
        sr_full <= 1'b0; btc <= 1'b1; tbe <= 1'b1;
      end
      if (rx_land) begin
        dr_q <= rx_byte; dr_full <= 1'b1; rbne <= 1'b1;
      end
      if (rx_wait) begin
        sr_q <= rx_byte; sr_full <= 1'b1; btc <= 1'b1;
      end
      if (rd_pull) begin
        dr_q <= sr_q; sr_full <= 1'b0; btc <= 1'b0;
      end
      if (rd_empty) begin
        dr_full <= 1'b0; rbne <= 1'b0;
      end
    end
  end

  p_direct_keeps_tbe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_direct |=> (sr_full && tbe == $past(tbe) && !btc));
  p_fill_clears_tbe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fill |=> !tbe);
  p_move_sets_tbe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_move |=> (tbe && sr_full));
  p_drain_btc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drain |=> (btc && !sr_full));
  p_rd_clears_rbne_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty |=> !rbne);
  p_rd_pull_keeps_rbne_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pull |=> (rbne && !btc && dr_q == $past(sr_q)));
endmodule

// File: rtl/i2c_stop_track.sv
module i2c_stop_track (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_set,
  input  logic stat_rd,
  input  logic ctrl_wr,
  output logic stop_q
);
  logic armed;
  logic clr_ev;
  assign clr_ev = ctrl_wr && armed && !stop_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= 1'b0; armed <= 1'b0;
    end else if (stop_set) begin
      stop_q <= 1'b1; armed <= 1'b0;
    end else if (clr_ev) begin
      stop_q <= 1'b0; armed <= 1'b0;
    end else if (stat_rd && stop_q) begin
      armed <= 1'b1;
    end
  end

  p_stop_needs_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && ctrl_wr && !armed) |=> stop_q);
  p_stop_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_set |=> stop_q);
endmodule

// File: rtl/i2c_buf_flags.sv
module i2c_buf_flags
  import i2c_buf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          eng_tx_mode,
  input  logic          eng_rx_done,
  input  logic [DW-1:0] eng_rx_byte,
  input  logic          eng_tx_done,
  output logic [DW-1:0] sh_tx_byte,
  output logic          sh_tx_valid,
  input  logic          eng_mid_byte,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_nack,
  input  logic          ev_arb_lost,
  input  logic          mst_start
  ,output logic         is_master
);
  localparam int I_BERR = 0;
  localparam int I_ARB  = 1;
  localparam int I_ACK  = 2;
  localparam int I_OU   = 3;

  logic wr_data, rd_data, wr_stat, rd_stat, wr_ctrl;
  logic stretch_dis;
  logic [DW-1:0] dr_q, sr_q;
  logic sr_full, ou_event, arb_drop, stop_slave;
  logic [NERR-1:0] err_set, err_clr, err_q;
  buf_flags_t fl;

  assign wr_data = reg_wr && reg_addr == A_DATA;
  assign rd_data = reg_rd && reg_addr == A_DATA;
  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign rd_stat = reg_rd && reg_addr == A_STAT;
  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;

  assign arb_drop   = ev_arb_lost && is_master;
  assign stop_slave = ev_stop && !is_master;

  always_ff @(posedge clk) begin
    if (!rst_n)       stretch_dis <= 1'b0;
    else if (wr_ctrl) stretch_dis <= reg_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    is_master <= 1'b0;
    else if (arb_drop || ev_stop)  is_master <= 1'b0;
    else if (mst_start)            is_master <= 1'b1;
  end

  i2c_byte_path #(.DW(DW)) u_path (
    .clk(clk), .rst_n(rst_n), .tx_mode(eng_tx_mode),
    .wr_data(wr_data), .wdata(reg_wdata[DW-1:0]), .rd_data(rd_data),
    .rx_done(eng_rx_done), .rx_byte(eng_rx_byte), .tx_done(eng_tx_done),
    .stretch_dis(stretch_dis), .slave(!is_master),
    .dr_q(dr_q), .sr_q(sr_q), .sr_full(sr_full),
    .tbe(fl.tbe), .rbne(fl.rbne), .btc(fl.btc), .ou_event(ou_event)
  );

  i2c_stop_track u_stop (
    .clk(clk), .rst_n(rst_n), .stop_set(stop_slave),
    .stat_rd(rd_stat), .ctrl_wr(wr_ctrl), .stop_q(fl.stop)
  );

  always_comb begin
    err_set = '0;
    err_set[I_BERR] = (ev_start || ev_stop) && eng_mid_byte;
    err_set[I_ARB]  = arb_drop;
    err_set[I_ACK]  = ev_nack;
    err_set[I_OU]   = ou_event;
  end

  for (genvar i = 0; i < NERR; i++) begin : g_err
    assign err_clr[i] = wr_stat && !reg_wdata[B_ERR0+i];
    i2c_w0c_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(err_set[i]),
      .clr_i(err_clr[i]), .q_o(err_q[i])
    );
  end

  assign sh_tx_byte  = sr_q;
  assign sh_tx_valid = eng_tx_mode && sr_full;

  always_comb begin
    unique case (reg_addr)
      A_DATA:  reg_rdata = {{(RW-DW){1'b0}}, dr_q};
      A_STAT:  reg_rdata = pack_status(err_q, fl);
      A_CTRL:  reg_rdata = {{(RW-1){1'b0}}, stretch_dis};
      default: reg_rdata = '0;
    endcase
  end

  p_arb_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arb_drop |=> (!is_master && err_q[I_ARB]));
  p_arb_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arb_lost && !is_master && !mst_start) |=> !is_master);
  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STAT) |-> (reg_rdata[5] == 1'b0 && reg_rdata[3] == 1'b0));
  p_master_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && is_master) |=> !is_master);
endmodule

// File: tb/i2c_buf_flags_bench.sv
module i2c_buf_flags_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic eng_tx_mode = 1'b0, eng_rx_done = 1'b0, eng_tx_done = 1'b0;
  logic [7:0] eng_rx_byte = 8'd0;
  logic [7:0] sh_tx_byte;
  logic sh_tx_valid;
  logic eng_mid_byte = 1'b0, ev_start = 1'b0, ev_stop = 1'b0;
  logic ev_nack = 1'b0, ev_arb_lost = 1'b0, mst_start = 1'b0;
  logic is_master;
  int n_chk = 0, n_err = 0;
  logic [15:0] v;

  always #2.5 clk = ~clk;

  i2c_buf_flags u_i2c_buf_flags (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_mode(eng_tx_mode), .eng_rx_done(eng_rx_done),
    .eng_rx_byte(eng_rx_byte), .eng_tx_done(eng_tx_done),
    .sh_tx_byte(sh_tx_byte), .sh_tx_valid(sh_tx_valid),
    .eng_mid_byte(eng_mid_byte), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_nack(ev_nack), .ev_arb_lost(ev_arb_lost), .mst_start(mst_start),
    .is_master(is_master)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic txm);
    @(negedge clk);
    rst_n = 1'b0; eng_tx_mode = txm;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // peek: no strobe, no side effect
  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_tx_done();
    @(negedge clk); eng_tx_done = 1'b1; @(negedge clk); eng_tx_done = 1'b0;
  endtask

  task automatic pulse_rx(input logic [7:0] b);
    @(negedge clk); eng_rx_done = 1'b1; eng_rx_byte = b;
    @(negedge clk); eng_rx_done = 1'b0;
  endtask

  task automatic pulse_mst();
    @(negedge clk); mst_start = 1'b1; @(negedge clk); mst_start = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    // R1 reset state
    do_reset(1'b1);
    peek(2'd1, v); check("R1 status", v, 0);
    peek(2'd2, v); check("R1 ctrl", v, 0);
    check("R1 is_master", is_master, 0);
    check("R1 sh_tx_valid", sh_tx_valid, 0);

    // R2/R3/R4 transmit path
    wr(2'd0, 16'h00A5);
    check("R2 valid", sh_tx_valid, 1); check("R2 byte", sh_tx_byte, 8'hA5);
    peek(2'd1, v); check("R2 tbe unchanged", v, 16'h0000);
    wr(2'd0, 16'h003C);
    peek(2'd1, v); check("R3 fill tbe", v, 16'h0000);
    pulse_tx_done();
    check("R3 move byte", sh_tx_byte, 8'h3C);
    peek(2'd1, v); check("R3 tbe set", v, 16'h0080);
    wr(2'd0, 16'h0011);
    peek(2'd1, v); check("R3 write clears tbe", v, 16'h0000);
    pulse_tx_done();
    check("R3 move2", sh_tx_byte, 8'h11);
    pulse_tx_done();
    check("R4 drained", sh_tx_valid, 0);
    peek(2'd1, v); check("R4 btc tbe", v, 16'h0084);
    wr(2'd0, 16'h0022);
    check("R2 direct byte", sh_tx_byte, 8'h22);
    peek(2'd1, v); check("R2 tbe kept btc cleared", v, 16'h0080);

    // R4 under-run sweep
    for (int c = 0; c < 4; c++) begin
      logic sd, m;
      sd = c[0]; m = c[1];
      do_reset(1'b1);
      wr(2'd2, {15'd0, sd});
      if (m) pulse_mst();
      wr(2'd0, 16'h0077);
      pulse_tx_done();
      peek(2'd1, v);
      check("R4 underrun sweep", v, ((sd && !m) ? 16'h0800 : 16'h0) | 16'h0084);
    end

    // R5/R6 receive path
    do_reset(1'b0);
    pulse_rx(8'h5A);
    peek(2'd1, v); check("R5 rbne", v, 16'h0040);
    rd(2'd0, v); check("R5 data", v, 16'h005A);
    peek(2'd1, v); check("R5 rbne cleared", v, 16'h0000);
    for (int c = 0; c < 4; c++) begin
      logic sd, m;
      sd = c[0]; m = c[1];
      do_reset(1'b0);
      wr(2'd2, {15'd0, sd});
      if (m) pulse_mst();
      pulse_rx(8'h01 + 8'(c));
      pulse_rx(8'h81 + 8'(c));
      peek(2'd1, v);
      check("R6 overrun sweep", v, ((sd && !m) ? 16'h0800 : 16'h0) | 16'h0044);
      rd(2'd0, v); check("R6 older byte", v, 16'h0001 + 16'(c));
      peek(2'd1, v);
      check("R6 rbne kept", v, ((sd && !m) ? 16'h0800 : 16'h0) | 16'h0040);
      rd(2'd0, v); check("R6 newer byte", v, 16'h0081 + 16'(c));
      peek(2'd1, v);
      check("R5 rbne after second read", v, (sd && !m) ? 16'h0800 : 16'h0);
    end

    // R7 nack, write-1 no effect
    do_reset(1'b0);
    @(negedge clk); ev_nack = 1'b1; @(negedge clk); ev_nack = 1'b0;
    peek(2'd1, v); check("R7 nack", v, 16'h0400);
    wr(2'd1, 16'hFFFF);
    peek(2'd1, v); check("R7 write 1 no effect", v, 16'h0400);

    // R9 bus error
    @(negedge clk); ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
    peek(2'd1, v); check("R9 idle start", v, 16'h0400);
    @(negedge clk); eng_mid_byte = 1'b1; ev_start = 1'b1;
    @(negedge clk); ev_start = 1'b0; eng_mid_byte = 1'b0;
    peek(2'd1, v); check("R9 mid start", v, 16'h0500);

    // R8 arbitration
    @(negedge clk); ev_arb_lost = 1'b1; @(negedge clk); ev_arb_lost = 1'b0;
    peek(2'd1, v); check("R8 slave arb ignored", v, 16'h0500);
    pulse_mst();
    check("R8 master", is_master, 1);
    @(negedge clk); ev_arb_lost = 1'b1; @(negedge clk); ev_arb_lost = 1'b0;
    check("R8 dropped", is_master, 0);
    peek(2'd1, v); check("R8 lostarb", v, 16'h0700);

    // R7 clear-mask sweep over all four error flags
    for (int mk = 0; mk < 16; mk++) begin
      do_reset(1'b1);
      wr(2'd2, 16'h0001);
      wr(2'd0, 16'h0010);
      pulse_tx_done();
      @(negedge clk); ev_nack = 1'b1; eng_mid_byte = 1'b1; ev_start = 1'b1;
      @(negedge clk); ev_nack = 1'b0; eng_mid_byte = 1'b0; ev_start = 1'b0;
      pulse_mst();
      @(negedge clk); ev_arb_lost = 1'b1; @(negedge clk); ev_arb_lost = 1'b0;
      wr(2'd1, 16'(mk) << 8);
      peek(2'd1, v);
      check("R7 clear mask", int'(v[11:8]), mk);
    end

    // R10 STOP in slave mode
    do_reset(1'b0);
    @(negedge clk); ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
    peek(2'd1, v); check("R10 stop set", v, 16'h0010);
    wr(2'd2, 16'h0000);
    peek(2'd1, v); check("R10 ctrl alone keeps", v, 16'h0010);
    rd(2'd1, v); check("R10 read sees stop", v, 16'h0010);
    wr(2'd2, 16'h0001);
    peek(2'd1, v); check("R10 cleared", v, 16'h0000);
    peek(2'd2, v); check("R11 ctrl readback", v, 16'h0001);
    pulse_mst();
    @(negedge clk); ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
    peek(2'd1, v); check("R10 master stop no flag", v, 16'h0000);
    check("R10 master stop drops", is_master, 0);

    // R11 reserved bits with many flags set
    do_reset(1'b0);
    wr(2'd2, 16'h0001);
    pulse_rx(8'h01); pulse_rx(8'h02);
    @(negedge clk); ev_nack = 1'b1; ev_stop = 1'b1; eng_mid_byte = 1'b1;
    @(negedge clk); ev_nack = 1'b0; ev_stop = 1'b0; eng_mid_byte = 1'b0;
    peek(2'd1, v); check("R11 reserved zero", v & 16'hF02B, 0);
    check("R11 full word", v, 16'h0D54);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule